// File: doc/BRIEF.md
# Pixel Stream Mode and Row Tracker

This control unit follows a raster stream of pixels, one per valid strobe, through a square image of 2^COL_W columns by 2^ROW_W rows (256 by 256 by default). It reports the processing mode on a 2-bit port and the row of the most recent pixel on a row port. It also exposes the column and row where the next pixel will land, so that line buffers and window logic can use them as write addresses. Pixel data and the edge computation sit outside the unit. That logic pulses a done input once the final result of an image has left the pipeline.

A synchronous reset forces a dedicated reset mode. The unit leaves it one cycle after reset falls. The first accepted pixel moves the unit from idle to busy. It stays busy until the whole image has been received and the done pulse has arrived. While it waits for that pulse it takes in no further pixels, so every image is exactly the full pixel count. The state register's all-zero encoding is the power-up state, and it reads as idle.

Top module: `stream_mode_tracker`

## Requirements
- R1: The mode port encodes reset as 2'b01, idle as 2'b10 and busy as 2'b11, and never shows 2'b00.
- R2: When reset is high at a clock edge, the next cycle shows mode 2'b01, with the column, row and last-row outputs at 0. This holds for as long as reset stays high.
- R3: In the first cycle after reset is sampled low, the mode is idle.
- R4: Each accepted pixel moves the column output up by one in the next cycle. From the last column it wraps to 0 and moves the row output up by one, and the row wraps to 0 after the last row.
- R5: The last-row output shows the row of the most recently accepted pixel. It is 0 after reset and reads the highest row index once the final pixel of an image has been accepted.
- R6: The first pixel accepted while idle makes the mode busy in the next cycle.
- R7: After the final pixel of an image, the mode stays busy until a done pulse. The cycle after that pulse shows idle, with column and row at 0.
- R8: A done pulse before the image is complete, or while idle, has no effect on the mode or the counters.
- R9: A valid strobe is ignored while reset is high, in reset mode, and between the final pixel and the done pulse. Column, row and last-row outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | One-cycle strobe marking a pixel on the stream |
| result_done | input | 1 | Pulse when the final result of the image has been emitted |
| mode | output | 2 | Processing mode: 01 reset, 10 idle, 11 busy |
| cur_row | output | ROW_W | Row of the most recently accepted pixel |
| col_cnt | output | COL_W | Column the next pixel will occupy |
| row_cnt | output | ROW_W | Row the next pixel will occupy |

## Verification
All state in the unit is visible one cycle after the edge that changed it. A miscounted column or a wrong wrap shows up on the counter ports at the next sample. A lost or spurious image-complete flag shows up later: the mode either leaves busy on an early done pulse, or ignores the real one. So the stimulus sends done pulses both mid-image and after completion. It also sends extra pixels after the final one, to expose a missing acceptance gate before the next image begins.

// File: rtl/stream_trk_pkg.sv
package stream_trk_pkg;

    // State encoding doubles as the mode code; 2'b00 is the power-up value.
    typedef enum logic [1:0] {
        ST_PWRUP = 2'b00,
        ST_RESET = 2'b01,
        ST_IDLE  = 2'b10,
        ST_BUSY  = 2'b11
    } trk_state_e;

    localparam logic [1:0] MODE_RESET = 2'b01;
    localparam logic [1:0] MODE_IDLE  = 2'b10;
    localparam logic [1:0] MODE_BUSY  = 2'b11;

endpackage

// File: rtl/stream_pos_ctr.sv
module stream_pos_ctr #(
    parameter int COL_W = 8,
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [COL_W-1:0] col_o,
    output logic [ROW_W-1:0] row_o,
    output logic [ROW_W-1:0] cur_row_o,
    output logic             at_last_o
);

    localparam logic [COL_W-1:0] COL_LAST = '1;
    localparam logic [ROW_W-1:0] ROW_LAST = '1;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic [ROW_W-1:0] cur;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (rst) begin
            pos_d = '0;
        end else if (adv) begin
            pos_d.cur = pos_q.row;
            if (pos_q.col == COL_LAST) begin
                pos_d.col = '0;
                pos_d.row = pos_q.row + 1'b1;
            end else begin
                pos_d.col = pos_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        pos_q <= pos_d;
    end

    assign col_o     = pos_q.col;
    assign row_o     = pos_q.row;
    assign cur_row_o = pos_q.cur;
    assign at_last_o = (pos_q.col == COL_LAST) && (pos_q.row == ROW_LAST);

    // R4: column steps by one inside a row
    a_r4_col_step: assert property (@(posedge clk) disable iff (rst)
        adv && (pos_q.col != COL_LAST) |=> pos_q.col == COL_W'($past(pos_q.col) + 1'b1));

    // R4: end of row wraps the column and advances the row
    a_r4_row_wrap: assert property (@(posedge clk) disable iff (rst)
        adv && (pos_q.col == COL_LAST) |=> (pos_q.col == '0) && (pos_q.row == ROW_W'($past(pos_q.row) + 1'b1)));

    // R5: last-row output follows the row the pixel landed in
    a_r5_cur_row: assert property (@(posedge clk) disable iff (rst)
        adv |=> pos_q.cur == $past(pos_q.row));

    // R9: nothing moves without an accepted pixel
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(pos_q.col) && $stable(pos_q.row) && $stable(pos_q.cur));

endmodule

// File: rtl/stream_mode_fsm.sv
module stream_mode_fsm
    import stream_trk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pix_valid,
    input  logic       done,
    input  logic       at_last,
    output logic       accept_o,
    output logic [1:0] mode_o
);

    typedef struct packed {
        trk_state_e st;
        logic       full;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    assign accept_o = pix_valid && !rst && !ctl_q.full &&
                      ((ctl_q.st == ST_IDLE) || (ctl_q.st == ST_BUSY));

    always_comb begin
        ctl_d = ctl_q;
        if (rst) begin
            ctl_d.st   = ST_RESET;
            ctl_d.full = 1'b0;
        end else begin
            if (accept_o && at_last) begin
                ctl_d.full = 1'b1;
            end
            unique case (ctl_q.st)
                ST_PWRUP, ST_RESET: ctl_d.st = ST_IDLE;
                ST_IDLE: begin
                    if (accept_o) ctl_d.st = ST_BUSY;
                end
                ST_BUSY: begin
                    if (ctl_q.full && done) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.full = 1'b0;
                    end
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign mode_o = (ctl_q.st == ST_PWRUP) ? MODE_IDLE : ctl_q.st;

    // R1: mode port never shows the unused code
    a_r1_legal_mode: assert property (@(posedge clk) disable iff (rst)
        mode_o != 2'b00);

    // R6: first pixel while idle starts the image
    a_r6_busy_start: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_IDLE) && accept_o |=> mode_o == MODE_BUSY);

    // R7: completed image plus done returns to idle
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        ctl_q.full && done |=> mode_o == MODE_IDLE);

    // R8: busy persists without a completing done pulse
    a_r8_hold_busy: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_BUSY) && !(ctl_q.full && done) |=> mode_o == MODE_BUSY);

endmodule

// File: rtl/stream_mode_tracker.sv
module stream_mode_tracker #(
    parameter int COL_W = 8,
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_valid,
    input  logic             result_done,
    output logic [1:0]       mode,
    output logic [ROW_W-1:0] cur_row,
    output logic [COL_W-1:0] col_cnt,
    output logic [ROW_W-1:0] row_cnt
);

    logic accept;
    logic at_last;

    stream_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pix_valid (pix_valid),
        .done      (result_done),
        .at_last   (at_last),
        .accept_o  (accept),
        .mode_o    (mode)
    );

    stream_pos_ctr #(
        .COL_W (COL_W),
        .ROW_W (ROW_W)
    ) u_pos (
        .clk       (clk),
        .rst       (rst),
        .adv       (accept),
        .col_o     (col_cnt),
        .row_o     (row_cnt),
        .cur_row_o (cur_row),
        .at_last_o (at_last)
    );

endmodule

// File: tb/stream_mode_tracker_tb.sv
`timescale 1ns/1ps
module stream_mode_tracker_tb_top;

    localparam int CW   = 2;
    localparam int RW   = 2;
    localparam int CMAX = (1 << CW) - 1;
    localparam int RMAX = (1 << RW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pix_valid = 1'b0;
    logic          result_done = 1'b0;
    logic [1:0]    mode;
    logic [RW-1:0] cur_row;
    logic [CW-1:0] col_cnt;
    logic [RW-1:0] row_cnt;

    always #5 clk = ~clk;

    stream_mode_tracker #(.COL_W(CW), .ROW_W(RW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .pix_valid   (pix_valid),
        .result_done (result_done),
        .mode        (mode),
        .cur_row     (cur_row),
        .col_cnt     (col_cnt),
        .row_cnt     (row_cnt)
    );

    typedef struct {
        int    mode;
        int    col;
        int    row;
        int    cur;
        string tag;
    } exp_t;

    exp_t sb[$];
    exp_t e;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    // reference model state
    int m_mode = 1;
    int m_col  = 0;
    int m_row  = 0;
    int m_cur  = 0;
    bit m_full = 0;

    task automatic cyc(input bit v, input bit d, input bit r, input string tag);
        bit acc;
        @(negedge clk);
        pix_valid   = v;
        result_done = d;
        rst         = r;
        if (r) begin
            m_mode = 1; m_col = 0; m_row = 0; m_cur = 0; m_full = 0;
        end else if (m_mode == 1) begin
            m_mode = 2;
        end else begin
            acc = v && !m_full;
            if (acc) begin
                m_cur = m_row;
                if (m_mode == 2) m_mode = 3;
                if (m_col == CMAX) begin
                    m_col = 0;
                    if (m_row == RMAX) begin
                        m_row  = 0;
                        m_full = 1;
                    end else begin
                        m_row++;
                    end
                end else begin
                    m_col++;
                end
            end else if (m_full && d) begin
                m_mode = 2;
                m_full = 0;
            end
        end
        sb.push_back('{m_mode, m_col, m_row, m_cur, tag});
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (int'(mode) != e.mode || int'(col_cnt) != e.col ||
                int'(row_cnt) != e.row || int'(cur_row) != e.cur) begin
                errors++;
                $display("FAIL %s: mode=%0d col=%0d row=%0d cur=%0d expected mode=%0d col=%0d row=%0d cur=%0d",
                         e.tag, mode, col_cnt, row_cnt, cur_row, e.mode, e.col, e.row, e.cur);
            end
        end
    end

    initial begin
        // R2: reset held, with a strobe during reset (R9)
        repeat (3) cyc(0, 0, 1, "R2");
        cyc(1, 0, 1, "R9");
        repeat (2) cyc(0, 0, 1, "R2");
        // R3: release; strobe in reset mode ignored
        cyc(1, 0, 0, "R3");
        // R1 / R8: done pulse while idle has no effect
        cyc(0, 1, 0, "R8");
        cyc(0, 0, 0, "R1");
        // R6: first pixel starts busy
        cyc(1, 0, 0, "R6");
        repeat (3) cyc(0, 0, 0, "R5");
        for (int k = 1; k < (CMAX + 1) * (RMAX + 1); k++) begin
            cyc(1, 0, 0, "R4");
            if (k == 7) cyc(0, 1, 0, "R8");
            repeat (2) cyc(0, 0, 0, "R5");
        end
        // R9: extra pixels after the final one are ignored
        cyc(1, 0, 0, "R9");
        cyc(1, 0, 0, "R9");
        cyc(0, 0, 0, "R7");
        // R7: done ends the image
        cyc(0, 1, 0, "R7");
        cyc(0, 0, 0, "R7");
        // second image, back-to-back pixels
        repeat (6) cyc(1, 0, 0, "R4");
        // R2: reset mid-image with strobes held high (R9)
        cyc(1, 0, 1, "R2");
        repeat (4) cyc(1, 0, 1, "R9");
        cyc(0, 0, 0, "R3");
        cyc(1, 0, 0, "R6");
        cyc(0, 0, 0, "R5");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule